// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Engine

This block derives the bit timing of a CAN node from its module clock. A programmable divider produces a time-quantum tick. A segment sequencer steps each nominal bit through four parts: a one-quantum synchronization part, a propagation part, a first phase buffer and a second phase buffer. The sequencer marks the sample point with a strobe and the sampled line value, and it marks the end of every bit with a second strobe.

Falling transitions of the receive line (recessive 1 to dominant 0) keep the timing aligned to other nodes. While the bus is idle, the controller raises `hsync_en`, and a transition restarts the bit outright. At other times a transition moves the sample point and the bit end by at most the programmed jump width, and only once per bit. Frame decoding, stuffing and error handling belong to the surrounding controller. That controller holds the configuration stable while timing runs.

Top module: `can_bit_timing`

## Requirements
- R1: `tq_tick` is a one-cycle pulse that repeats every D clocks. When `brp_wide`=1, D = `brp_div`+1, which gives ratios of 2 to 256. When `brp_wide`=0, D = `brp_div[6:0]`+1, because bit 7 is ignored, which gives ratios of 2 to 128.
- R2: Segment fields hold their length minus one. The propagation length is P = `prop_seg`+1, the first phase length is P1 = `ph1_seg`+1, and the jump width is SJW = `sjw_tq`+1. `ipt_tq` is a plain quantum count from 0 to 2. The second phase length is P2 = max(P1, `ipt_tq`). The nominal bit length is T = 1+P+P1+P2 quanta.
- R3: While `hsync_en`=1, a falling `rx` transition hard-synchronizes the bit. Call the first clock edge that sees `rx` low edge 0; the synchronization quantum starts there. With no later transition, `sample_stb` is high in the cycle after edge (1+P+P1)·D.
- R4: `sample_stb` and `bit_start` are one-cycle pulses and never coincide. `bit_start` marks the end of the second phase. After a hard sync the first `bit_start` follows edge T·D, and every later undisturbed bit lasts exactly T·D clocks.
- R5: `rx_bit` takes the value `rx` has just before the clock edge that raises `sample_stb`, and it changes at no other time. Its reset value is 1.
- R6: A falling transition whose first low cycle falls in quantum q is handled as follows, counting the synchronization quantum of the bit as q=0 and a quantum as ending with the tick that closes it. If q lies in the propagation or first phase part (1 ≤ q ≤ P+P1), the first phase is lengthened by min(q, SJW). This delays both strobes by that many quanta.
- R7: A falling transition in the second phase at position c (0-based, c = q−1−P−P1) shortens that phase by min(P2−c−1, SJW). This moves `bit_start` earlier and leaves `sample_stb` where it was.
- R8: A transition in the synchronization quantum changes nothing. Once one transition has adjusted a bit, further transitions in the same bit change nothing. The next bit starts with nominal lengths.
- R9: `config_error` is 1 when D would be 1, when `ipt_tq`=3, or when T lies outside 8 to 25. While it is 1, `tq_tick`, `sample_stb` and `bit_start` stay low and transitions on `rx` are ignored.
- R10: An undisturbed bit contains exactly T pulses of `tq_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| brp_div | input | 8 | Divider field: ratio minus one |
| brp_wide | input | 1 | 1 selects the full 8-bit divider range |
| prop_seg | input | 3 | Propagation length minus one |
| ph1_seg | input | 3 | First phase length minus one |
| ipt_tq | input | 2 | Processing time in quanta (0 to 2) |
| sjw_tq | input | 2 | Jump width minus one |
| hsync_en | input | 1 | Bus idle: a falling edge hard-synchronizes |
| rx | input | 1 | Receive line, already synchronized to clk |
| tq_tick | output | 1 | One pulse per time quantum |
| sample_stb | output | 1 | Pulse at the sample point |
| rx_bit | output | 1 | Line value taken at the last sample point |
| bit_start | output | 1 | Pulse at the end of each bit |
| config_error | output | 1 | Current configuration is illegal |

## Verification
Each case starts with a hard sync. The case then either leaves the line quiet, or drops it once in a chosen quantum of the synchronization, propagation, first phase or second phase part, or drops it twice in one bit. The quiet cases pin down the nominal sample and bit positions. Single late and early edges separate lengthening from shortening and show where the jump width caps each. The double edge and the synchronization-quantum edge show the one-per-bit rule and the dead zone. Divider values above 127 in both range modes, together with configurations just inside and just outside the legal bit length, separate the range masking and the legality checks. Random legal configurations with random edge positions cover the combinations between these points.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    localparam int BRP_W   = 8;
    localparam int SEGF_W  = 3;
    localparam int SJWF_W  = 2;
    localparam int IPT_W   = 2;
    localparam int LEN_W   = 5;
    localparam int SUM_W   = LEN_W + 1;
    localparam int IPT_MAX = 2;
    localparam int NBT_MIN = 8;
    localparam int NBT_MAX = 25;

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    typedef enum logic [1:0] {
        SEG_SYNC,
        SEG_PROP,
        SEG_PH1,
        SEG_PH2
    } seg_e;

    typedef struct packed {
        logic [BRP_W-1:0]  brp;
        logic              wide;
        logic [SEGF_W-1:0] prop;
        logic [SEGF_W-1:0] ph1;
        logic [IPT_W-1:0]  ipt;
        logic [SJWF_W-1:0] sjw;
    } bt_cfg_t;

    typedef struct packed {
        logic [BRP_W-1:0] div_m1;
        logic [LEN_W-1:0] prop_len;
        logic [LEN_W-1:0] ph1_len;
        logic [LEN_W-1:0] ph2_len;
        logic [LEN_W-1:0] sjw_len;
        logic             bad;
    } bt_time_t;

    function automatic logic [LEN_W-1:0] len_min(input logic [LEN_W-1:0] a,
                                                 input logic [LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [LEN_W-1:0] len_max(input logic [LEN_W-1:0] a,
                                                 input logic [LEN_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [LEN_W-1:0] field_len(input logic [LEN_W-1:0] f);
        return f + LEN_ONE;
    endfunction

endpackage

// File: rtl/can_bt_decode.sv
module can_bt_decode
    import can_bt_pkg::*;
(
    input  bt_cfg_t  cfg,
    output bt_time_t tm
);

    logic [SUM_W-1:0] total;

    always_comb begin
        tm.div_m1   = cfg.wide ? cfg.brp : {1'b0, cfg.brp[BRP_W-2:0]};
        tm.prop_len = field_len(LEN_W'(cfg.prop));
        tm.ph1_len  = field_len(LEN_W'(cfg.ph1));
        tm.ph2_len  = len_max(tm.ph1_len, LEN_W'(cfg.ipt));
        tm.sjw_len  = field_len(LEN_W'(cfg.sjw));
        total       = SUM_W'(1) + SUM_W'(tm.prop_len) + SUM_W'(tm.ph1_len)
                    + SUM_W'(tm.ph2_len);
        tm.bad      = (tm.div_m1 == '0)
                   || (cfg.ipt > IPT_W'(IPT_MAX))
                   || (total < SUM_W'(NBT_MIN))
                   || (total > SUM_W'(NBT_MAX));
    end

endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             restart,
    input  logic [BRP_W-1:0] div_m1,
    output logic             tick
);

    logic [BRP_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || hold || restart) begin
            cnt <= '0;
        end else if (cnt == div_m1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = !hold && (cnt == div_m1);

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R1

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
    import can_bt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bt_time_t tm,
    input  logic     tick,
    input  logic     hsync_en,
    input  logic     rx,
    output logic     hard,
    output logic     sample_stb,
    output logic     rx_bit,
    output logic     bit_start
);

    seg_e             seg;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] ph1_ext;
    logic [LEN_W-1:0] ph2_red;
    logic             rs_done;
    logic             pend;
    logic             rx_prev;

    logic             fall;
    logic             soft_edge;
    logic             edge_now;
    logic             do_rs;
    logic             end_seg;
    logic [LEN_W-1:0] late_err;
    logic [LEN_W-1:0] early_err;
    logic [LEN_W-1:0] ext_nxt;
    logic [LEN_W-1:0] red_nxt;

    assign fall      = rx_prev & ~rx;
    assign hard      = hsync_en & fall & ~tm.bad;
    assign soft_edge = ~hsync_en & fall & ~tm.bad & ~rs_done;

    // Phase error of a pending edge, resolved at the tick closing its quantum
    always_comb begin
        edge_now  = (pend | soft_edge) & ~rs_done;
        late_err  = (seg == SEG_PH1) ? (tm.prop_len + cnt + LEN_ONE) : (cnt + LEN_ONE);
        early_err = tm.ph2_len - ph2_red - cnt - LEN_ONE;
        ext_nxt   = ph1_ext;
        red_nxt   = ph2_red;
        do_rs     = 1'b0;
        if (edge_now) begin
            case (seg)
                SEG_PROP, SEG_PH1: begin
                    ext_nxt = ph1_ext + len_min(late_err, tm.sjw_len);
                    do_rs   = 1'b1;
                end
                SEG_PH2: begin
                    red_nxt = ph2_red + len_min(early_err, tm.sjw_len);
                    do_rs   = 1'b1;
                end
                default: ;
            endcase
        end
        case (seg)
            SEG_SYNC: end_seg = 1'b1;
            SEG_PROP: end_seg = (cnt == tm.prop_len - LEN_ONE);
            SEG_PH1:  end_seg = (cnt == tm.ph1_len + ext_nxt - LEN_ONE);
            default:  end_seg = (cnt == tm.ph2_len - red_nxt - LEN_ONE);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_prev    <= 1'b1;
            seg        <= SEG_SYNC;
            cnt        <= '0;
            ph1_ext    <= '0;
            ph2_red    <= '0;
            rs_done    <= 1'b0;
            pend       <= 1'b0;
            sample_stb <= 1'b0;
            bit_start  <= 1'b0;
            rx_bit     <= 1'b1;
        end else begin
            rx_prev    <= rx;
            sample_stb <= 1'b0;
            bit_start  <= 1'b0;
            if (tm.bad || hard) begin
                seg     <= SEG_SYNC;
                cnt     <= '0;
                ph1_ext <= '0;
                ph2_red <= '0;
                rs_done <= 1'b0;
                pend    <= 1'b0;
            end else if (tick) begin
                pend    <= 1'b0;
                ph1_ext <= ext_nxt;
                ph2_red <= red_nxt;
                if (do_rs) begin
                    rs_done <= 1'b1;
                end
                if (end_seg) begin
                    cnt <= '0;
                    case (seg)
                        SEG_SYNC: seg <= SEG_PROP;
                        SEG_PROP: seg <= SEG_PH1;
                        SEG_PH1: begin
                            seg        <= SEG_PH2;
                            sample_stb <= 1'b1;
                            rx_bit     <= rx;
                        end
                        default: begin
                            seg       <= SEG_SYNC;
                            bit_start <= 1'b1;
                            ph1_ext   <= '0;
                            ph2_red   <= '0;
                            rs_done   <= 1'b0;
                        end
                    endcase
                end else begin
                    cnt <= cnt + LEN_ONE;
                end
            end else if (soft_edge) begin
                pend <= 1'b1;
            end
        end
    end

    AST_SYNC_ONE_TQ: assert property (@(posedge clk) disable iff (rst)
        (seg == SEG_SYNC && tick && !hard && !tm.bad) |=> (seg == SEG_PROP)); // R3

    AST_SAMPLE_IN_PH2: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> (seg == SEG_PH2)); // R4

    AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> !bit_start); // R4

    AST_EXT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        ph1_ext <= tm.sjw_len); // R6

    AST_RED_LIMIT: assert property (@(posedge clk) disable iff (rst)
        ph2_red <= tm.sjw_len); // R7

    AST_RXBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |-> $stable(rx_bit)); // R5

endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
    import can_bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BRP_W-1:0]  brp_div,
    input  logic              brp_wide,
    input  logic [SEGF_W-1:0] prop_seg,
    input  logic [SEGF_W-1:0] ph1_seg,
    input  logic [IPT_W-1:0]  ipt_tq,
    input  logic [SJWF_W-1:0] sjw_tq,
    input  logic              hsync_en,
    input  logic              rx,
    output logic              tq_tick,
    output logic              sample_stb,
    output logic              rx_bit,
    output logic              bit_start,
    output logic              config_error
);

    bt_cfg_t  cfg;
    bt_time_t tm;
    logic     hard;

    assign cfg = '{brp: brp_div, wide: brp_wide, prop: prop_seg, ph1: ph1_seg,
                   ipt: ipt_tq, sjw: sjw_tq};

    can_bt_decode u_decode (
        .cfg (cfg),
        .tm  (tm)
    );

    can_bt_prescaler u_prescaler (
        .clk     (clk),
        .rst     (rst),
        .hold    (tm.bad),
        .restart (hard),
        .div_m1  (tm.div_m1),
        .tick    (tq_tick)
    );

    can_bt_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .tm         (tm),
        .tick       (tq_tick),
        .hsync_en   (hsync_en),
        .rx         (rx),
        .hard       (hard),
        .sample_stb (sample_stb),
        .rx_bit     (rx_bit),
        .bit_start  (bit_start)
    );

    assign config_error = tm.bad;

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        config_error |=> (!sample_stb && !bit_start)); // R9

endmodule

// File: tb/can_bit_timing_bench.sv
module can_bit_timing_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] brp_div = 8'd3;
    logic       brp_wide = 1'b0;
    logic [2:0] prop_seg = 3'd2;
    logic [2:0] ph1_seg = 3'd3;
    logic [1:0] ipt_tq = 2'd0;
    logic [1:0] sjw_tq = 2'd1;
    logic       hsync_en = 1'b0;
    logic       rx = 1'b1;
    logic       tq_tick, sample_stb, rx_bit, bit_start, config_error;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    can_bit_timing u_can_bit_timing (
        .clk(clk), .rst(rst), .brp_div(brp_div), .brp_wide(brp_wide),
        .prop_seg(prop_seg), .ph1_seg(ph1_seg), .ipt_tq(ipt_tq), .sjw_tq(sjw_tq),
        .hsync_en(hsync_en), .rx(rx), .tq_tick(tq_tick), .sample_stb(sample_stb),
        .rx_bit(rx_bit), .bit_start(bit_start), .config_error(config_error)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic set_cfg(input int brp, input int wide, input int prop,
                           input int ph1, input int ipt, input int sjw);
        @(negedge clk);
        hsync_en = 1'b0;
        rx       = 1'b1;
        brp_div  = 8'(brp);
        brp_wide = wide[0];
        prop_seg = 3'(prop);
        ph1_seg  = 3'(ph1);
        ipt_tq   = 2'(ipt);
        sjw_tq   = 2'(sjw);
        repeat (3) @(negedge clk);
    endtask

    // Hard sync, optional edges at offsets x1/x2, then two bits measured
    task automatic run_case(input int brp, input int wide, input int prop, input int ph1,
                            input int ipt, input int sjw, input int x1, input int x2,
                            input string tag);
        int d, p, p1, p2, sj, t, q, c, ext, red, s_exp, b_exp, k;
        int s_at, b1, b2, ticks, sbit, exp_bit;
        d  = (wide != 0 ? brp : (brp & 127)) + 1;
        p  = prop + 1;
        p1 = ph1 + 1;
        p2 = (p1 > ipt) ? p1 : ipt;
        sj = sjw + 1;
        t  = 1 + p + p1 + p2;
        ext = 0;
        red = 0;
        if (x1 > 0) begin
            q = (x1 - 1) / d;
            if (q >= 1 && q <= p + p1) begin
                ext = imin(q, sj);
            end else if (q > p + p1) begin
                c   = q - 1 - p - p1;
                red = imin(p2 - c - 1, sj);
            end
        end
        s_exp = (1 + p + p1 + ext) * d;
        b_exp = (t + ext - red) * d;
        exp_bit = 1;
        if (x1 > 0 && s_exp >= x1) exp_bit = 0;
        if (x2 > 0 && s_exp >= x1 + 1 && s_exp < x2) exp_bit = 1;

        set_cfg(brp, wide, prop, ph1, ipt, sjw);
        chk(config_error == 1'b0, {tag, " R9 legal config accepted"}, int'(config_error), 0);
        hsync_en = 1'b1;
        rx       = 1'b0;
        k        = cyc + 1;
        s_at = -1; b1 = -1; b2 = -1; ticks = 0; sbit = -1;
        while (b2 < 0) begin
            @(negedge clk);
            if (cyc == k) begin
                hsync_en = 1'b0;
                rx       = 1'b1;
            end
            if (x1 > 0 && cyc == k + x1 - 1) rx = 1'b0;
            if (x2 > 0 && cyc == k + x1) rx = 1'b1;
            if (x2 > 0 && cyc == k + x2 - 1) rx = 1'b0;
            if (sample_stb && s_at < 0) begin
                s_at = cyc;
                sbit = int'(rx_bit);
            end
            if (tq_tick && b1 >= 0) ticks++;
            if (bit_start) begin
                if (b1 < 0) b1 = cyc;
                else b2 = cyc;
            end
        end
        chk(s_at - k == s_exp, {tag, " R3 R6 sample point"}, s_at - k, s_exp);
        chk(sbit == exp_bit, {tag, " R5 sampled bit"}, sbit, exp_bit);
        chk(b1 - k == b_exp, {tag, " R4 R7 R8 bit end"}, b1 - k, b_exp);
        chk(b2 - b1 == t * d, {tag, " R4 R8 next bit nominal"}, b2 - b1, t * d);
        chk(ticks == t, {tag, " R1 R10 quanta per bit"}, ticks, t);
    endtask

    task automatic err_case(input int brp, input int wide, input int prop, input int ph1,
                            input int ipt, input int sjw, input string tag);
        int seen;
        set_cfg(brp, wide, prop, ph1, ipt, sjw);
        chk(config_error == 1'b1, {tag, " R9 flag"}, int'(config_error), 1);
        hsync_en = 1'b1;
        rx       = 1'b0;
        seen     = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (i == 1) begin
                hsync_en = 1'b0;
                rx       = 1'b1;
            end
            if (i == 50) rx = 1'b0;
            if (tq_tick || sample_stb || bit_start) seen++;
        end
        chk(seen == 0, {tag, " R9 timing held idle"}, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int brp, wide, prop, ph1, ipt, sjw, d, t, x1;
        repeat (3) @(negedge clk);
        chk(sample_stb == 1'b0, "R4 reset sample_stb", int'(sample_stb), 0);
        chk(bit_start == 1'b0, "R4 reset bit_start", int'(bit_start), 0);
        chk(rx_bit == 1'b1, "R5 reset rx_bit", int'(rx_bit), 1);
        rst = 1'b0;
        @(negedge clk);

        // nominal: D=4, P=3, P1=4, P2=4, SJW=2, T=12
        run_case(3, 0, 2, 3, 0, 1, 0, 0, "nominal");
        run_case(3, 0, 2, 3, 0, 1, 6, 0, "late q1");
        run_case(3, 0, 2, 3, 0, 1, 26, 0, "late q6 capped");
        run_case(3, 0, 2, 3, 0, 1, 37, 0, "early c1");
        run_case(3, 0, 2, 3, 0, 1, 45, 0, "early last quantum");
        run_case(3, 0, 2, 3, 0, 1, 2, 0, "edge in sync");
        run_case(3, 0, 2, 3, 0, 1, 6, 30, "second edge ignored");
        run_case(3, 0, 2, 3, 0, 3, 26, 0, "late q6 sjw4");
        // phase 2 derivation
        run_case(2, 0, 7, 0, 2, 0, 0, 0, "R2 ipt dominates");
        run_case(2, 0, 7, 0, 0, 0, 0, 0, "R2 ph1 dominates");
        // divider range modes, T=8
        run_case(200, 0, 2, 1, 0, 0, 0, 0, "R1 narrow mode");
        run_case(200, 1, 2, 1, 0, 0, 0, 0, "R1 wide mode");
        // length limits
        run_case(1, 0, 7, 7, 0, 3, 0, 0, "T=25");
        err_case(1, 0, 1, 1, 0, 0, "T=7");
        err_case(0, 1, 2, 3, 0, 0, "ratio 1");
        err_case(128, 0, 2, 3, 0, 0, "R1 masked ratio 1");
        err_case(2, 0, 2, 3, 3, 0, "ipt 3");

        void'($urandom(32'd20240611));
        for (int n = 0; n < 25; n++) begin
            brp  = int'($urandom_range(1, 5));
            wide = int'($urandom_range(0, 1));
            prop = int'($urandom_range(0, 7));
            ph1  = int'($urandom_range(0, 7));
            ipt  = int'($urandom_range(0, 2));
            sjw  = int'($urandom_range(0, 3));
            t    = 1 + (prop + 1) + (ph1 + 1) + (((ph1 + 1) > ipt) ? (ph1 + 1) : ipt);
            if (t < 8) prop = 7;
            t    = 1 + (prop + 1) + (ph1 + 1) + (((ph1 + 1) > ipt) ? (ph1 + 1) : ipt);
            d    = brp + 1;
            x1   = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(2, t * d));
            run_case(brp, wide, prop, ph1, ipt, sjw, x1, 0, "random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule